// File: doc/BRIEF.md
# Processor Mode and Exception Controller

This block holds the operating mode of a 32-bit processor core and the two interrupt-disable bits. When an exception request arrives it picks one winner, reports the mode that the exception enters, and pulses two strobes. In that cycle the register file copies the current status word into the saved status register of the target mode and writes the return address into that mode's link register. The new mode and mask bits take effect at the next clock edge.

Software can write the mode and mask bits through a status-write port, but only from a privileged mode. An exception-return input restores the mode and mask bits from the saved status word that the register file supplies for the current mode. A privilege output lets memory controllers refuse accesses from unprivileged code. Vector addresses, decode and pipeline flushing are handled elsewhere.

Top module: `mode_exc_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after it is released, the block is in Supervisor mode (code 10011) with both mask bits set. Both save strobes are low.
- R2: `mode_o` only ever holds one of seven codes: User 10000, FIQ 10001, IRQ 10010, Supervisor 10011, Abort 10111, Undefined 11011, System 11111. `priv_o` is low only in User mode.
- R3: A taken exception enters its own mode. Abort enters Abort, fast interrupt enters FIQ, normal interrupt enters IRQ, undefined instruction enters Undefined, and software interrupt enters Supervisor. `exc_mode_o` shows the target code in the request cycle. `mode_o` changes at the next edge.
- R4: When several unmasked requests are present in the same cycle, the winner is chosen in this order, highest first: abort, fast interrupt, normal interrupt, undefined, software interrupt.
- R5: FIQ entry sets both the I and the F mask bits. Any other exception entry sets I and leaves F unchanged.
- R6: A normal interrupt is ignored while I is set. A fast interrupt is ignored while F is set. When a masked request is the only request, no strobe fires and the state does not change.
- R7: No exception ever targets System mode. A privileged status write can enter System mode.
- R8: In User mode, status writes are ignored: the mode, I and F all stay unchanged.
- R9: In a privileged mode, a status write loads the mode from bits [4:0], F from bit 6 and I from bit 7 of `psr_wdata_i`. A write whose mode field is not one of the seven codes is ignored entirely.
- R10: Exception return loads the mode, I and F from `saved_psr_i` (same bit positions as R9), but only in FIQ, IRQ, Supervisor, Abort and Undefined modes. It is ignored in User and System mode, and when the saved mode field is not a legal code.
- R11: In the same cycle, a taken exception wins over exception return, and exception return wins over a status write.
- R12: `psr_o` carries the mode in bits [4:0], F in bit 6 and I in bit 7. All other bits are zero.
- R13: `save_psr_o` and `save_lr_o` both pulse for exactly the cycles in which an exception is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| abort_i | input | 1 | Memory access violation request |
| fiq_i | input | 1 | Fast interrupt request |
| irq_i | input | 1 | Normal interrupt request |
| undef_i | input | 1 | Undefined instruction request |
| swi_i | input | 1 | Software interrupt request |
| psr_wr_i | input | 1 | Status write enable |
| psr_wdata_i | input | PSR_W | Status write data |
| ret_i | input | 1 | Exception return |
| saved_psr_i | input | PSR_W | Saved status word of the current mode |
| mode_o | output | 5 | Current mode code |
| priv_o | output | 1 | High in privileged modes |
| irq_mask_o | output | 1 | I bit |
| fiq_mask_o | output | 1 | F bit |
| psr_o | output | PSR_W | Current status word |
| save_psr_o | output | 1 | Copy status word to target saved register |
| save_lr_o | output | 1 | Write return address to target link register |
| exc_mode_o | output | 5 | Target mode of the taken exception, zero otherwise |

## Verification
The bench builds the block with PSR_W=16, keeping the default positions of bit 7 for I and bit 6 for F. The narrow word puts bits 15:8 of `psr_o` within reach, so the check that they stay zero is exercised. The narrow word also lets every status write and every saved word be written as a short literal in the vector table. The table walks through every exception type and through writes from User, System and banked modes. It also covers returns from modes with and without a saved register, illegal mode fields, and requests that collide while a mask bit blocks part of them.

// File: rtl/mode_pkg.sv
package mode_pkg;
  localparam int MODE_W  = 5;
  localparam int NUM_EXC = 5;

  typedef enum logic [MODE_W-1:0] {
    M_USR = 5'b10000,
    M_FIQ = 5'b10001,
    M_IRQ = 5'b10010,
    M_SVC = 5'b10011,
    M_ABT = 5'b10111,
    M_UND = 5'b11011,
    M_SYS = 5'b11111
  } mode_e;

  // request index = priority rank, 0 highest
  localparam int EX_ABT = 0;
  localparam int EX_FIQ = 1;
  localparam int EX_IRQ = 2;
  localparam int EX_UND = 3;
  localparam int EX_SWI = 4;

  function automatic logic mode_legal(logic [MODE_W-1:0] m);
    case (m)
      M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic mode_priv(logic [MODE_W-1:0] m);
    return m != M_USR;
  endfunction

  // modes that own a saved status register
  function automatic logic mode_banked(logic [MODE_W-1:0] m);
    return (m != M_USR) && (m != M_SYS);
  endfunction

  function automatic logic [MODE_W-1:0] exc_target(int idx);
    case (idx)
      EX_ABT:  return M_ABT;
      EX_FIQ:  return M_FIQ;
      EX_IRQ:  return M_IRQ;
      EX_UND:  return M_UND;
      default: return M_SVC;
    endcase
  endfunction
endpackage

// File: rtl/exc_prio.sv
module exc_prio #(
  parameter int N = 5
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_rank
    assign gnt_o[i]  = req_i[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req_i[i];
  end

  assign any_o = seen[N];
endmodule

// File: rtl/exc_map.sv
module exc_map
  import mode_pkg::*;
#(
  parameter int N = NUM_EXC
) (
  input  logic [N-1:0]      gnt_i,
  output logic [MODE_W-1:0] tgt_o,
  output logic              set_f_o
);
  always_comb begin
    tgt_o = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt_i[i]) tgt_o = tgt_o | exc_target(i);
    end
  end

  assign set_f_o = gnt_i[EX_FIQ];
endmodule

// File: rtl/mode_reg.sv
module mode_reg
  import mode_pkg::*;
#(
  parameter int PSR_W = 32,
  parameter int I_POS = 7,
  parameter int F_POS = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [MODE_W-1:0] tgt_i,
  input  logic              set_f_i,
  input  logic              ret_i,
  input  logic [PSR_W-1:0]  spsr_i,
  input  logic              wr_i,
  input  logic [PSR_W-1:0]  wdata_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              i_o,
  output logic              f_o
);
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              i_q, i_d, f_q, f_d;
  logic              ret_ok, wr_ok;

  assign ret_ok = ret_i && mode_banked(mode_q) && mode_legal(spsr_i[MODE_W-1:0]);
  assign wr_ok  = wr_i && mode_priv(mode_q) && mode_legal(wdata_i[MODE_W-1:0]);

  always_comb begin
    mode_d = mode_q;
    i_d    = i_q;
    f_d    = f_q;
    if (take_i) begin
      mode_d = tgt_i;
      i_d    = 1'b1;
      f_d    = f_q | set_f_i;
    end else if (ret_ok) begin
      mode_d = spsr_i[MODE_W-1:0];
      i_d    = spsr_i[I_POS];
      f_d    = spsr_i[F_POS];
    end else if (wr_ok) begin
      mode_d = wdata_i[MODE_W-1:0];
      i_d    = wdata_i[I_POS];
      f_d    = wdata_i[F_POS];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_SVC;
      i_q    <= 1'b1;
      f_q    <= 1'b1;
    end else begin
      mode_q <= mode_d;
      i_q    <= i_d;
      f_q    <= f_d;
    end
  end

  assign mode_o = mode_q;
  assign i_o    = i_q;
  assign f_o    = f_q;
endmodule

// File: rtl/mode_exc_ctrl.sv
module mode_exc_ctrl
  import mode_pkg::*;
#(
  parameter int PSR_W = 32,
  parameter int I_POS = 7,
  parameter int F_POS = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              fiq_i,
  input  logic              irq_i,
  input  logic              undef_i,
  input  logic              swi_i,
  input  logic              psr_wr_i,
  input  logic [PSR_W-1:0]  psr_wdata_i,
  input  logic              ret_i,
  input  logic [PSR_W-1:0]  saved_psr_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              priv_o,
  output logic              irq_mask_o,
  output logic              fiq_mask_o,
  output logic [PSR_W-1:0]  psr_o,
  output logic              save_psr_o,
  output logic              save_lr_o,
  output logic [MODE_W-1:0] exc_mode_o
);
  logic [NUM_EXC-1:0] req, gnt;
  logic               take, set_f;
  logic [MODE_W-1:0]  tgt;
  logic               i_bit, f_bit;

  always_comb begin
    req         = '0;
    req[EX_ABT] = abort_i;
    req[EX_FIQ] = fiq_i & ~f_bit;
    req[EX_IRQ] = irq_i & ~i_bit;
    req[EX_UND] = undef_i;
    req[EX_SWI] = swi_i;
  end

  exc_prio #(.N(NUM_EXC)) u_prio (
    .req_i (req),
    .gnt_o (gnt),
    .any_o (take)
  );

  exc_map #(.N(NUM_EXC)) u_map (
    .gnt_i   (gnt),
    .tgt_o   (tgt),
    .set_f_o (set_f)
  );

  mode_reg #(.PSR_W(PSR_W), .I_POS(I_POS), .F_POS(F_POS)) u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (take),
    .tgt_i   (tgt),
    .set_f_i (set_f),
    .ret_i   (ret_i),
    .spsr_i  (saved_psr_i),
    .wr_i    (psr_wr_i),
    .wdata_i (psr_wdata_i),
    .mode_o  (mode_o),
    .i_o     (i_bit),
    .f_o     (f_bit)
  );

  always_comb begin
    psr_o               = '0;
    psr_o[MODE_W-1:0]   = mode_o;
    psr_o[I_POS]        = i_bit;
    psr_o[F_POS]        = f_bit;
  end

  assign priv_o     = mode_priv(mode_o);
  assign irq_mask_o = i_bit;
  assign fiq_mask_o = f_bit;
  assign save_psr_o = take;
  assign save_lr_o  = take;
  assign exc_mode_o = tgt;
endmodule

// File: rtl/mode_exc_chk.sv
module mode_exc_chk
  import mode_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              abort_i,
  input logic              psr_wr_i,
  input logic              ret_i,
  input logic [MODE_W-1:0] mode_o,
  input logic              priv_o,
  input logic              irq_mask_o,
  input logic              fiq_mask_o,
  input logic              save_psr_o,
  input logic              save_lr_o,
  input logic [MODE_W-1:0] exc_mode_o
);
  assert_legal_mode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_legal(mode_o));

  assert_priv_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_o == (mode_o != M_USR));

  assert_enter_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_psr_o |=> mode_o == $past(exc_mode_o));

  assert_abort_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_psr_o && abort_i) |-> exc_mode_o == M_ABT);

  assert_fiq_masks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_psr_o && exc_mode_o == M_FIQ) |=> (irq_mask_o && fiq_mask_o));

  assert_fiq_unmasked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_psr_o && exc_mode_o == M_FIQ) |-> !fiq_mask_o);

  assert_no_sys_entry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_psr_o |-> exc_mode_o != M_SYS);

  assert_user_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_USR && psr_wr_i && !ret_i && !save_psr_o)
      |=> (mode_o == M_USR && $stable(irq_mask_o) && $stable(fiq_mask_o)));

  assert_strobe_pair_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_psr_o == save_lr_o);
endmodule

bind mode_exc_ctrl mode_exc_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .abort_i    (abort_i),
  .psr_wr_i   (psr_wr_i),
  .ret_i      (ret_i),
  .mode_o     (mode_o),
  .priv_o     (priv_o),
  .irq_mask_o (irq_mask_o),
  .fiq_mask_o (fiq_mask_o),
  .save_psr_o (save_psr_o),
  .save_lr_o  (save_lr_o),
  .exc_mode_o (exc_mode_o)
);

// File: tb/sim_mode_exc_ctrl.sv
module sim_mode_exc_ctrl;
  localparam int PW = 16;
  localparam int NV = 22;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          abort_i = 0, fiq_i = 0, irq_i = 0, undef_i = 0, swi_i = 0;
  logic          psr_wr_i = 0, ret_i = 0;
  logic [PW-1:0] psr_wdata_i = '0, saved_psr_i = '0;
  logic [4:0]    mode_o, exc_mode_o;
  logic          priv_o, irq_mask_o, fiq_mask_o, save_psr_o, save_lr_o;
  logic [PW-1:0] psr_o;

  int total = 0;
  int bad   = 0;

  always #2 clk_i = ~clk_i;

  mode_exc_ctrl #(.PSR_W(PW)) u0 (
    .clk_i, .rst_ni, .abort_i, .fiq_i, .irq_i, .undef_i, .swi_i,
    .psr_wr_i, .psr_wdata_i, .ret_i, .saved_psr_i,
    .mode_o, .priv_o, .irq_mask_o, .fiq_mask_o, .psr_o,
    .save_psr_o, .save_lr_o, .exc_mode_o
  );

  typedef struct packed {
    logic [4:0]  req;  // {abort, fiq, irq, undef, swi}
    logic        wr;
    logic [15:0] wd;
    logic        ret;
    logic [15:0] sp;
    logic        sv;
    logic [4:0]  tm;
    logic [4:0]  md;
    logic        ei;
    logic        ef;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    {5'b00000, 1'b1, 16'h0013, 1'b0, 16'h0000, 1'b0, 5'h00, 5'h13, 1'b0, 1'b0}, // R9
    {5'b00100, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 5'h12, 5'h12, 1'b1, 1'b0}, // R3 irq
    {5'b00000, 1'b0, 16'h0000, 1'b1, 16'h0013, 1'b0, 5'h00, 5'h13, 1'b0, 1'b0}, // R10
    {5'b01000, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 5'h11, 5'h11, 1'b1, 1'b1}, // R3 R5 fiq
    {5'b00000, 1'b0, 16'h0000, 1'b1, 16'h0010, 1'b0, 5'h00, 5'h10, 1'b0, 1'b0}, // R10 to user
    {5'b00000, 1'b1, 16'h001F, 1'b0, 16'h0000, 1'b0, 5'h00, 5'h10, 1'b0, 1'b0}, // R8
    {5'b00000, 1'b0, 16'h0000, 1'b1, 16'h0013, 1'b0, 5'h00, 5'h10, 1'b0, 1'b0}, // R10 user ret
    {5'b00001, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 5'h13, 5'h13, 1'b1, 1'b0}, // R3 swi
    {5'b00000, 1'b1, 16'h001F, 1'b0, 16'h0000, 1'b0, 5'h00, 5'h1F, 1'b0, 1'b0}, // R7 to sys
    {5'b00000, 1'b0, 16'h0000, 1'b1, 16'h0012, 1'b0, 5'h00, 5'h1F, 1'b0, 1'b0}, // R10 sys ret
    {5'b00010, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 5'h1B, 5'h1B, 1'b1, 1'b0}, // R3 undef
    {5'b00000, 1'b1, 16'h0015, 1'b0, 16'h0000, 1'b0, 5'h00, 5'h1B, 1'b1, 1'b0}, // R9 illegal
    {5'b00000, 1'b1, 16'h001F, 1'b0, 16'h0000, 1'b0, 5'h00, 5'h1F, 1'b0, 1'b0}, // R9
    {5'b11111, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 5'h17, 5'h17, 1'b1, 1'b0}, // R4 abort
    {5'b01111, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 5'h11, 5'h11, 1'b1, 1'b1}, // R4 R6 fiq
    {5'b01110, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 5'h1B, 5'h1B, 1'b1, 1'b1}, // R5 R6 undef
    {5'b01100, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 5'h00, 5'h1B, 1'b1, 1'b1}, // R6 masked
    {5'b00000, 1'b1, 16'h0053, 1'b0, 16'h0000, 1'b0, 5'h00, 5'h13, 1'b0, 1'b1}, // R9
    {5'b01100, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 5'h12, 5'h12, 1'b1, 1'b1}, // R6 R5
    {5'b00001, 1'b1, 16'h001F, 1'b1, 16'h0013, 1'b1, 5'h13, 5'h13, 1'b1, 1'b1}, // R11
    {5'b00000, 1'b1, 16'h001F, 1'b1, 16'h0010, 1'b0, 5'h00, 5'h10, 1'b0, 1'b0}, // R11
    {5'b10000, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 5'h17, 5'h17, 1'b1, 1'b0}  // R3 abort
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag, input logic [4:0] md, input logic ei, input logic ef);
    chk({tag, " mode R2"}, mode_o, md);
    chk({tag, " I R5"}, irq_mask_o, ei);
    chk({tag, " F R5"}, fiq_mask_o, ef);
    chk({tag, " priv R2"}, priv_o, md != 5'h10);
    chk({tag, " psr R12"}, psr_o, {8'h00, ei, ef, 1'b0, md});
  endtask

  initial begin
    #(200000 * 4);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 during and after reset
    #5;
    chk_state("R1 in reset", 5'h13, 1'b1, 1'b1);
    chk("R1 strobe", save_psr_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk_state("R1 after", 5'h13, 1'b1, 1'b1);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk_i);
      {abort_i, fiq_i, irq_i, undef_i, swi_i} = VEC[k].req;
      psr_wr_i    = VEC[k].wr;
      psr_wdata_i = VEC[k].wd;
      ret_i       = VEC[k].ret;
      saved_psr_i = VEC[k].sp;
      #1;
      chk($sformatf("v%0d save R13", k), save_psr_o, VEC[k].sv);
      chk($sformatf("v%0d lr R13", k), save_lr_o, VEC[k].sv);
      if (VEC[k].sv) chk($sformatf("v%0d target R3 R7", k), exc_mode_o, VEC[k].tm);
      @(posedge clk_i); #1;
      chk_state($sformatf("v%0d", k), VEC[k].md, VEC[k].ei, VEC[k].ef);
    end

    @(negedge clk_i);
    {abort_i, fiq_i, irq_i, undef_i, swi_i} = '0;
    psr_wr_i = 0;
    ret_i    = 0;
    @(posedge clk_i); #1;
    chk("R13 strobe idle", save_psr_o, 0);

    // R1 asynchronous reset from Abort
    rst_ni = 1'b0;
    #1;
    chk_state("R1 async", 5'h13, 1'b1, 1'b1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk_state("R1 release", 5'h13, 1'b1, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule